// File: doc/BRIEF.md
# I2C Register Target with Loop-back Buffer

This block is an I2C target that answers at one fixed 7-bit address and exposes a 32-byte register space. It receives the raw SCL and SDA lines and passes them through a synchronizer of its own. It drives SDA open-drain, so it either pulls the line low or leaves it released. A register pointer chooses the byte that is accessed, and the pointer steps forward after every data byte.

A write transaction carries the address byte with the direction bit clear. The first data byte loads the pointer, and the bytes after it are stored from that offset upward. A read begins with a write that sets the pointer. A repeated START with the read address follows, and the target then sends bytes from the pointer until the master answers with a nack.

The space has four areas. Three 16-bit configuration fields hold the settings for a separate clock-stretch block. Six read-only bytes report two measurements that the same block supplies. Four bytes are reserved. Sixteen bytes form a loop-back buffer.

Top module: `i2c_regtarget`

## Requirements
- R1: While `rst` is high and after it falls, `sda_oe` is 0, all configuration outputs are zero, and every loop-back byte reads back 0x00.
- R2: An address byte of 0x44 (write) or 0x45 (read), that is the 7-bit address 0x22 followed by the direction bit, is acknowledged by pulling SDA low during the ninth clock. `sda_oe` rises only while the synchronized SCL is low.
- R3: In a write transaction the first data byte loads the pointer, using its low five bits. Each later byte is stored at the pointer. Every data byte is acknowledged.
- R4: Offsets 0x00–0x01, 0x02–0x03 and 0x04–0x05 hold `cfg_enable`, `cfg_pulse` and `cfg_stretch`. The more significant byte sits at the lower offset, and each field appears on its output port once written.
- R5: After a repeated START with 0x45, the target sends bytes MSB first, starting at the pointer. A master ack asks for the next byte. A master nack makes the target release SDA and stay silent until the next START.
- R6: Offsets 0x10–0x1F form a 16-byte loop-back buffer. Its contents survive across transactions and change only when written.
- R7: Offsets 0x06–0x07 read `q_pulse` and offsets 0x08–0x0B read `q_time`, the more significant byte at the lower offset. Writes to these offsets are acknowledged and discarded.
- R8: Offsets 0x0C–0x0F read 0x00. Writes to them are acknowledged and discarded.
- R9: The pointer advances by one after every data byte, read or write, and wraps from 0x1F to 0x00.
- R10: An address byte with any other 7-bit address is not acknowledged. The target then drives nothing and stores nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| q_pulse | input | 16 | Measured pulse count, readable at 0x06–0x07 |
| q_time | input | 32 | Measured duration, readable at 0x08–0x0B |
| cfg_enable | output | 16 | Configuration field at 0x00–0x01 |
| cfg_pulse | output | 16 | Configuration field at 0x02–0x03 |
| cfg_stretch | output | 16 | Configuration field at 0x04–0x05 |

## Verification
The assertions check these rules on every cycle:
- SDA is released in the idle and ignore states.
- The acknowledge drive starts only while SCL is low.
- SDA is released after a master nack.
- A write strobe lasts one cycle.
- The pointer wraps from 0x1F to 0x00 on a write.
- The loop-back and configuration storage stay unchanged unless a write targets them.

Only the bench scenarios can show the byte values. These include the field byte order, the query and reserved read-back, retention across transactions, wrap-around reads, and the silence that follows a foreign address.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;

    localparam int REG_AW     = 5;
    localparam int CFG_W      = 16;
    localparam int QP_W       = 16;
    localparam int QT_W       = 32;
    localparam int CFG_FIELDS = 3;
    localparam int CFG_BYTES  = CFG_W / 8;
    localparam int CTRL_BYTES = CFG_FIELDS * CFG_BYTES;
    localparam int Q_BYTES    = (QP_W + QT_W) / 8;
    localparam int MSG_BYTES  = 16;

    typedef logic [REG_AW-1:0] reg_addr_t;

    localparam reg_addr_t CTRL_BASE  = 5'h00;
    localparam reg_addr_t QUERY_BASE = 5'h06;
    localparam reg_addr_t RSVD_BASE  = 5'h0C;
    localparam reg_addr_t LOOP_BASE  = 5'h10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE,
        ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_IGNORE
    } eng_state_t;

    typedef enum logic [1:0] {
        AREA_CTRL, AREA_QUERY, AREA_RSVD, AREA_LOOP
    } area_t;

    // Synchronized line levels plus the bus events derived from them
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic      en;
        reg_addr_t addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic area_t area_of(input reg_addr_t a);
        if (a >= LOOP_BASE)  return AREA_LOOP;
        if (a >= RSVD_BASE)  return AREA_RSVD;
        if (a >= QUERY_BASE) return AREA_QUERY;
        return AREA_CTRL;
    endfunction

endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync
    import i2c_rt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    // bit 1 is SCL, bit 0 is SDA
    assign ev.scl   = synced[1];
    assign ev.sda   = synced[0];
    assign ev.rise  = synced[1] & ~prev[1];
    assign ev.fall  = ~synced[1] & prev[1];
    assign ev.start = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign ev.stop  = synced[1] & prev[1] & ~prev[0] & synced[0];

endmodule

// File: rtl/i2c_rt_engine.sv
module i2c_rt_engine
    import i2c_rt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h22
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rd_data,
    output reg_addr_t  rd_addr,
    output wr_req_t    wr,
    output logic       sda_oe
);

    eng_state_t state_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q;
    reg_addr_t  ptr_q;
    logic       need_ptr_q;
    logic       mack_q;
    logic       oe_q;
    wr_req_t    wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            sh_q       <= '0;
            ptr_q      <= '0;
            need_ptr_q <= 1'b1;
            mack_q     <= 1'b0;
            oe_q       <= 1'b0;
            wr_q       <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (ev.start) begin
                state_q    <= ST_ADDR;
                cnt_q      <= '0;
                oe_q       <= 1'b0;
                need_ptr_q <= 1'b1;
            end else if (ev.stop) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            sh_q  <= {sh_q[6:0], ev.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (ev.fall && cnt_q == 4'd8) begin
                            if (sh_q[7:1] == DEV_ADDR) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            cnt_q <= '0;
                            if (sh_q[0]) begin
                                sh_q    <= rd_data;
                                oe_q    <= ~rd_data[7];
                                ptr_q   <= ptr_q + 1'b1;
                                state_q <= ST_RD_BYTE;
                            end else begin
                                oe_q       <= 1'b0;
                                need_ptr_q <= 1'b1;
                                state_q    <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (ev.rise) begin
                            sh_q  <= {sh_q[6:0], ev.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (ev.fall && cnt_q == 4'd8) begin
                            oe_q    <= 1'b1;
                            state_q <= ST_WR_ACK;
                            if (need_ptr_q) begin
                                ptr_q      <= sh_q[REG_AW-1:0];
                                need_ptr_q <= 1'b0;
                            end else begin
                                wr_q.en   <= 1'b1;
                                wr_q.addr <= ptr_q;
                                wr_q.data <= sh_q;
                                ptr_q     <= ptr_q + 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.fall) begin
                            oe_q    <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (ev.fall) begin
                            if (cnt_q == 4'd8) begin
                                oe_q    <= 1'b0;
                                state_q <= ST_RD_ACK;
                            end else begin
                                sh_q <= {sh_q[6:0], 1'b0};
                                oe_q <= ~sh_q[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            mack_q <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (mack_q) begin
                                sh_q    <= rd_data;
                                oe_q    <= ~rd_data[7];
                                ptr_q   <= ptr_q + 1'b1;
                                cnt_q   <= '0;
                                state_q <= ST_RD_BYTE;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = ptr_q;
    assign wr      = wr_q;
    assign sda_oe  = oe_q;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !oe_q);  // R1
    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> !ev.scl);  // R2
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |=> !wr_q.en);  // R3
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD_ACK && ev.fall && !ev.start && !ev.stop && !mack_q) |=> !oe_q);  // R5
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_q.en && wr_q.addr == '1) |-> (ptr_q == '0 || $past(ev.start)));  // R9
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IGNORE) |-> (!oe_q && !wr_q.en));  // R10

endmodule

// File: rtl/i2c_rt_regs.sv
module i2c_rt_regs
    import i2c_rt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         wr,
    input  reg_addr_t       rd_addr,
    input  logic [QP_W-1:0] q_pulse,
    input  logic [QT_W-1:0] q_time,
    output logic [7:0]      rd_data,
    output logic [CFG_W-1:0] cfg_enable,
    output logic [CFG_W-1:0] cfg_pulse,
    output logic [CFG_W-1:0] cfg_stretch
);

    localparam int QV_W = Q_BYTES * 8;

    logic [7:0] ctrl_mem [CTRL_BYTES];
    logic [7:0] msg_mem  [MSG_BYTES];
    logic [CTRL_BYTES*8-1:0] ctrl_flat;
    logic [MSG_BYTES*8-1:0]  msg_flat;
    logic [QV_W-1:0]         qv;

    for (genvar i = 0; i < CTRL_BYTES; i++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_mem[i] <= '0;
            else if (wr.en && area_of(wr.addr) == AREA_CTRL &&
                     wr.addr == reg_addr_t'(int'(CTRL_BASE) + i))
                ctrl_mem[i] <= wr.data;
        end
        // lower offset carries the more significant byte
        assign ctrl_flat[CTRL_BYTES*8-1-8*i -: 8] = ctrl_mem[i];
    end

    for (genvar i = 0; i < MSG_BYTES; i++) begin : g_msg
        always_ff @(posedge clk) begin
            if (rst)
                msg_mem[i] <= '0;
            else if (wr.en && area_of(wr.addr) == AREA_LOOP &&
                     wr.addr == reg_addr_t'(int'(LOOP_BASE) + i))
                msg_mem[i] <= wr.data;
        end
        assign msg_flat[8*i +: 8] = msg_mem[i];
    end

    assign {cfg_enable, cfg_pulse, cfg_stretch} = ctrl_flat;
    assign qv = {q_pulse, q_time};

    always_comb begin
        rd_data = 8'h00;
        case (area_of(rd_addr))
            AREA_CTRL: begin
                for (int i = 0; i < CTRL_BYTES; i++)
                    if (rd_addr == reg_addr_t'(int'(CTRL_BASE) + i)) rd_data = ctrl_mem[i];
            end
            AREA_QUERY: begin
                for (int i = 0; i < Q_BYTES; i++)
                    if (rd_addr == reg_addr_t'(int'(QUERY_BASE) + i)) rd_data = qv[QV_W-1-8*i -: 8];
            end
            AREA_LOOP: begin
                for (int i = 0; i < MSG_BYTES; i++)
                    if (rd_addr == reg_addr_t'(int'(LOOP_BASE) + i)) rd_data = msg_mem[i];
            end
            default: rd_data = 8'h00;
        endcase
    end

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && area_of(wr.addr) == AREA_LOOP) |=> $stable(msg_flat));  // R6
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && area_of(wr.addr) == AREA_CTRL) |=> $stable(ctrl_flat));  // R4
    AST_DISCARD_RO: assert property (@(posedge clk) disable iff (rst)
        (wr.en && (area_of(wr.addr) == AREA_QUERY || area_of(wr.addr) == AREA_RSVD))
        |=> ($stable(ctrl_flat) && $stable(msg_flat)));  // R8

endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget
    import i2c_rt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h22,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [15:0] q_pulse,
    input  logic [31:0] q_time,
    output logic [15:0] cfg_enable,
    output logic [15:0] cfg_pulse,
    output logic [15:0] cfg_stretch
);

    bus_ev_t    ev;
    reg_addr_t  rd_addr;
    wr_req_t    wr;
    logic [7:0] rd_data;

    i2c_rt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rt_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    i2c_rt_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_addr     (rd_addr),
        .q_pulse     (q_pulse),
        .q_time      (q_time),
        .rd_data     (rd_data),
        .cfg_enable  (cfg_enable),
        .cfg_pulse   (cfg_pulse),
        .cfg_stretch (cfg_stretch)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk)
        rst |=> !sda_oe);  // R1

endmodule

// File: tb/sim_i2c_regtarget.sv
module sim_i2c_regtarget;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [15:0] q_pulse = 16'hA1B2;
    logic [31:0] q_time  = 32'hC3D4E5F6;
    logic [15:0] cfg_enable, cfg_pulse, cfg_stretch;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regtarget u0 (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .q_pulse     (q_pulse),
        .q_time      (q_time),
        .cfg_enable  (cfg_enable),
        .cfg_pulse   (cfg_pulse),
        .cfg_stretch (cfg_stretch)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] act_q[$];
    logic [7:0] wbuf [32];
    logic [7:0] ebuf [32];

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor: pairs bytes read off the bus with predictions
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(e.req, {24'h0, a}, {24'h0, e.val}, "read byte");
            end
        end
    end

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;
        hq();
        scl_m = 1'b1;
        hq();
        s = sda_bus;
        hq();
        scl_m = 1'b0;
        hq();
    endtask

    task automatic m_start();
        if (scl_m == 1'b0) begin
            sda_m = 1'b1;
            hq();
            scl_m = 1'b1;
            hq();
        end
        sda_m = 1'b0;
        hq();
        scl_m = 1'b0;
        hq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0;
        hq();
        scl_m = 1'b1;
        hq();
        sda_m = 1'b1;
        hq();
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_read(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    // write wbuf[0..n-1] from ptr; every ack is checked
    task automatic write_seq(input logic [7:0] ptr, input int n, input string req);
        logic a;
        m_start();
        m_write(8'h44, a);
        check("R2", {31'h0, a}, 32'h1, "write address ack");
        m_write(ptr, a);
        check(req, {31'h0, a}, 32'h1, "pointer byte ack");
        for (int i = 0; i < n; i++) begin
            m_write(wbuf[i], a);
            check(req, {31'h0, a}, 32'h1, "data byte ack");
        end
        m_stop();
    endtask

    // read n bytes from ptr, predicting ebuf[0..n-1]
    task automatic read_seq(input logic [7:0] ptr, input int n, input string req);
        logic a;
        logic [7:0] v;
        m_start();
        m_write(8'h44, a);
        m_write(ptr, a);
        m_start();
        m_write(8'h45, a);
        check("R2", {31'h0, a}, 32'h1, "read address ack");
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = ebuf[i];
            e.req = req;
            exp_q.push_back(e);
            m_read(i != n - 1, v);
            act_q.push_back(v);
        end
        hq();
        check("R5", {31'h0, sda_oe}, 32'h0, "SDA released after nack");
        m_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        repeat (10) @(negedge clk);
        check("R1", {31'h0, sda_oe}, 32'h0, "sda_oe during reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", {31'h0, sda_oe}, 32'h0, "sda_oe after reset");
        check("R1", {16'h0, cfg_enable}, 32'h0, "cfg_enable after reset");
        check("R1", {16'h0, cfg_pulse | cfg_stretch}, 32'h0, "cfg fields after reset");
        ebuf[0] = 8'h00; ebuf[1] = 8'h00;
        read_seq(8'h10, 2, "R1");

        // configuration fields, MSB at lower offset
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
        wbuf[3] = 8'h78; wbuf[4] = 8'h9A; wbuf[5] = 8'hBC;
        write_seq(8'h00, 6, "R3");
        check("R4", {16'h0, cfg_enable}, 32'h1234, "cfg_enable");
        check("R4", {16'h0, cfg_pulse}, 32'h5678, "cfg_pulse");
        check("R4", {16'h0, cfg_stretch}, 32'h9ABC, "cfg_stretch");
        for (int i = 0; i < 6; i++) ebuf[i] = wbuf[i];
        read_seq(8'h00, 6, "R4");

        // loop-back buffer fill and read back in a later transaction
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(i * 17 + 3);
        write_seq(8'h10, 16, "R3");
        for (int i = 0; i < 16; i++) ebuf[i] = 8'(i * 17 + 3);
        read_seq(8'h10, 16, "R6");

        // query area is read-only, reserved area reads zero
        for (int i = 0; i < 10; i++) wbuf[i] = 8'h5A;
        write_seq(8'h06, 10, "R7");
        ebuf[0] = 8'hA1; ebuf[1] = 8'hB2; ebuf[2] = 8'hC3;
        ebuf[3] = 8'hD4; ebuf[4] = 8'hE5; ebuf[5] = 8'hF6;
        for (int i = 6; i < 10; i++) ebuf[i] = 8'h00;
        read_seq(8'h06, 6, "R7");
        for (int i = 0; i < 4; i++) ebuf[i] = 8'h00;
        read_seq(8'h0C, 4, "R8");
        check("R7", {16'h0, cfg_stretch}, 32'h9ABC, "cfg_stretch after discarded writes");

        // pointer wraps 0x1F -> 0x00 on write and on read
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'h77;
        write_seq(8'h1E, 3, "R9");
        check("R9", {16'h0, cfg_enable}, 32'h7734, "write wrapped to offset 0");
        ebuf[0] = 8'hE2; ebuf[1] = 8'h77; ebuf[2] = 8'h34;
        read_seq(8'h1F, 3, "R9");

        // foreign address: no ack, nothing stored until next START
        m_start();
        m_write(8'h46, a);
        check("R10", {31'h0, a}, 32'h0, "foreign address nack");
        m_write(8'h00, a);
        check("R10", {31'h0, a}, 32'h0, "byte after foreign address");
        m_write(8'h99, a);
        check("R10", {31'h0, a}, 32'h0, "second byte after foreign address");
        m_stop();
        check("R10", {16'h0, cfg_enable}, 32'h7734, "cfg_enable untouched");
        m_start();
        m_write(8'h47, a);
        check("R10", {31'h0, a}, 32'h0, "foreign read address nack");
        m_stop();

        // retained buffer after other traffic
        for (int i = 0; i < 4; i++) ebuf[i] = 8'(i * 17 + 3);
        read_seq(8'h10, 4, "R6");

        repeat (20) @(negedge clk);
        check("R5", exp_q.size(), 32'h0, "all predicted bytes consumed");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule